// File: doc/BRIEF.md
# Single-Port RAM with Selectable Write Policy

This block is a synchronous single-port memory. It has one clock and one address. An access happens only when the enable input is high. The write-enable input then chooses between storing the input word and fetching the addressed word. Every result appears on a registered output, here called the output latch, one clock edge after the access.

When a port writes, it must also decide what to put on its own output. A compile-time parameter picks one of three policies:

- **write-first:** the output shows the new word.
- **read-first:** the output shows the word that was overwritten.
- **no-change:** the output keeps its last value.

A second parameter adds an extra output register stage behind the latch. That stage costs one more cycle of latency and loads only when its own enable input is high. A reset clears the latch and the extra stage to zero, so the output is defined before the first access. The reset leaves the storage array untouched.

Top module: `spram_wmode`

## Requirements
- R1: With `en`=1 and `we`=0, the word stored at `addr` appears on the output latch after the next rising clock edge. With `OUT_REG`=0, that latch drives `rdata` directly.
- R2: With `WRITE_POLICY`=0 (write-first), an access with `en`=1 and `we`=1 stores `wdata` at `addr`, and `wdata` appears on the output latch after that edge.
- R3: With `WRITE_POLICY`=1 (read-first), a write stores `wdata`, and the output latch shows the word that `addr` held before the write.
- R4: With `WRITE_POLICY`=2 (no-change), a write stores `wdata`, and the output latch keeps its previous value.
- R5: With `en`=0, nothing is stored and the output latch holds, whatever `we`, `addr` and `wdata` carry.
- R6: With `OUT_REG`=1, `rdata` equals the output latch value from one edge earlier. Read latency is therefore two edges.
- R7: While `rst_n` is low, the output latch and the extra output stage are zero. `rdata` therefore reads all zeros before the first enabled access.
- R8: With `OUT_REG`=1 and `oreg_ce`=0, `rdata` holds its value across the edge, even when the latch changes.
- R9: Reset does not alter the stored words. A word written before a reset reads back unchanged after the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the output stages |
| en | input | 1 | Access enable; low blocks both read and write |
| we | input | 1 | Write enable, meaningful only while `en` is high |
| addr | input | ADDR_W | Word address, ADDR_W = clog2(DEPTH) |
| wdata | input | DATA_W | Word to store |
| oreg_ce | input | 1 | Load enable of the optional output register |
| rdata | output | DATA_W | Read data, from the latch or from the extra stage |

## Verification
Read-first is the hard case to observe. Its output on a write is the word being replaced, so it differs from write-first only when the address already holds a different value. The stimulus therefore overwrites a word that was written earlier and has just been read. A disabled cycle carrying a write of a marker value is then followed by a read of the same address, which shows at the port that the word survived. Four instances (write-first, read-first, no-change, and read-first with the extra stage) see the same stimulus, and each is compared with its own reference model.

// File: rtl/spram_pkg.sv
package spram_pkg;
  // Encoding of the same-port write policy parameter
  localparam int POL_WRITE_FIRST = 0;
  localparam int POL_READ_FIRST  = 1;
  localparam int POL_NO_CHANGE   = 2;

  // True when the policy code names a supported behaviour
  function automatic bit policy_ok(input int pol);
    return (pol >= POL_WRITE_FIRST) && (pol <= POL_NO_CHANGE);
  endfunction

  // Address width needed to cover a given word count (minimum 1)
  function automatic int addr_bits(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction
endpackage

// File: rtl/spram_store.sv
module spram_store #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              wr_fire,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] old_word
);
  logic [DATA_W-1:0] mem [DEPTH];

  // Word currently held at the address, before any write at this edge
  assign old_word = mem[addr];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[addr] <= wdata;
  end
endmodule

// File: rtl/spram_outlatch.sv
module spram_outlatch #(
  parameter int DATA_W = 16,
  parameter int POLICY = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_fire,
  input  logic              wr_fire,
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] latch_q
);
  import spram_pkg::*;

  logic [DATA_W-1:0] on_write;
  logic              load;

  // Value presented on a write, chosen by the policy
  always_comb begin
    case (POLICY)
      POL_WRITE_FIRST: on_write = wdata;
      POL_READ_FIRST:  on_write = old_word;
      default:         on_write = latch_q;
    endcase
  end

  assign load = rd_fire | wr_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       latch_q <= '0;
    else if (rd_fire) latch_q <= old_word;
    else if (load)    latch_q <= on_write;
  end
endmodule

// File: rtl/spram_pipe.sv
module spram_pipe #(
  parameter int DATA_W  = 16,
  parameter bit OUT_REG = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stage_q <= '0;
    else if (ce)  stage_q <= din;
  end

  // The parameter selects the registered or the direct path
  assign dout = OUT_REG ? stage_q : din;
endmodule

// File: rtl/spram_wmode.sv
module spram_wmode #(
  parameter int DATA_W       = 16,
  parameter int DEPTH        = 256,
  parameter int WRITE_POLICY = 0,
  parameter bit OUT_REG      = 1'b0,
  localparam int ADDR_W      = spram_pkg::addr_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              oreg_ce,
  output logic [DATA_W-1:0] rdata
);
  // Named internal events, visible to the bound checker
  logic              wr_fire;
  logic              rd_fire;
  logic [DATA_W-1:0] old_word;
  logic [DATA_W-1:0] latch_q;

  assign wr_fire = en & we;
  assign rd_fire = en & ~we;

  spram_store #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)
  ) u_store (
    .clk(clk), .wr_fire(wr_fire), .addr(addr),
    .wdata(wdata), .old_word(old_word)
  );

  spram_outlatch #(
    .DATA_W(DATA_W), .POLICY(WRITE_POLICY)
  ) u_latch (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .wr_fire(wr_fire),
    .old_word(old_word), .wdata(wdata), .latch_q(latch_q)
  );

  spram_pipe #(
    .DATA_W(DATA_W), .OUT_REG(OUT_REG)
  ) u_pipe (
    .clk(clk), .rst_n(rst_n), .ce(oreg_ce),
    .din(latch_q), .dout(rdata)
  );

  initial begin
    if (!spram_pkg::policy_ok(WRITE_POLICY))
      $error("spram_wmode: unsupported WRITE_POLICY %0d", WRITE_POLICY);
  end
endmodule

// File: rtl/spram_wmode_chk.sv
module spram_wmode_chk #(
  parameter int DATA_W  = 16,
  parameter int POLICY  = 0,
  parameter bit OUT_REG = 1'b0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              we,
  input logic [DATA_W-1:0] wdata,
  input logic              oreg_ce,
  input logic [DATA_W-1:0] rdata,
  input logic [DATA_W-1:0] latch_q,
  input logic [DATA_W-1:0] old_word
);
  a_r1_read_word: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !we) |=> latch_q == $past(old_word));

  a_r2_write_first: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == 0 && en && we) |=> latch_q == $past(wdata));

  a_r3_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == 1 && en && we) |=> latch_q == $past(old_word));

  a_r4_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (POLICY == 2 && en && we) |=> $stable(latch_q));

  a_r5_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(latch_q));

  a_r6_extra_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && oreg_ce) |=> rdata == $past(latch_q));

  a_r6_direct_path: assert property (@(posedge clk)
    !OUT_REG |-> rdata == latch_q);

  a_r7_reset_zero: assert property (@(posedge clk)
    !rst_n |=> rdata == '0);

  a_r8_stage_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (OUT_REG && !oreg_ce) |=> $stable(rdata));
endmodule

bind spram_wmode spram_wmode_chk #(
  .DATA_W(DATA_W), .POLICY(WRITE_POLICY), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .we(we), .wdata(wdata),
  .oreg_ce(oreg_ce), .rdata(rdata), .latch_q(latch_q), .old_word(old_word)
);

// File: tb/spram_wmode_tb.sv
module spram_wmode_tb;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int NVEC = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0, we = 1'b0, oreg_ce = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rd_wf, rd_rf, rd_nc, rd_pp;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  spram_wmode #(.WRITE_POLICY(0), .OUT_REG(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .addr(addr),
    .wdata(wdata), .oreg_ce(oreg_ce), .rdata(rd_wf));
  spram_wmode #(.WRITE_POLICY(1), .OUT_REG(1'b0)) u_dut_rf (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .addr(addr),
    .wdata(wdata), .oreg_ce(oreg_ce), .rdata(rd_rf));
  spram_wmode #(.WRITE_POLICY(2), .OUT_REG(1'b0)) u_dut_nc (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .addr(addr),
    .wdata(wdata), .oreg_ce(oreg_ce), .rdata(rd_nc));
  spram_wmode #(.WRITE_POLICY(1), .OUT_REG(1'b1)) u_dut_pp (
    .clk(clk), .rst_n(rst_n), .en(en), .we(we), .addr(addr),
    .wdata(wdata), .oreg_ce(oreg_ce), .rdata(rd_pp));

  // Reference model
  logic [DW-1:0] ref_mem [256];
  logic [DW-1:0] exp_wf = '0, exp_rf = '0, exp_nc = '0, exp_pp = '0;

  // Vector fields: {en, we, addr[7:0], wdata[15:0]}
  localparam logic [25:0] VEC [NVEC] = '{
    {1'b1, 1'b1, 8'h10, 16'h1111},
    {1'b1, 1'b1, 8'h20, 16'h2222},
    {1'b1, 1'b0, 8'h10, 16'h0000},
    {1'b0, 1'b1, 8'h10, 16'hDEAD},
    {1'b1, 1'b0, 8'h10, 16'h0000},
    {1'b1, 1'b1, 8'h10, 16'h3333},
    {1'b1, 1'b1, 8'h30, 16'h4444},
    {1'b1, 1'b0, 8'h20, 16'h0000},
    {1'b1, 1'b1, 8'h20, 16'h5555},
    {1'b0, 1'b0, 8'h30, 16'hBEEF},
    {1'b1, 1'b0, 8'h30, 16'h0000},
    {1'b1, 1'b1, 8'hFF, 16'hFFFF},
    {1'b1, 1'b1, 8'h00, 16'h0001},
    {1'b1, 1'b0, 8'hFF, 16'h0000}
  };

  task automatic chk(input string tag, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  task automatic step(input logic e, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic ce);
    logic [DW-1:0] old;
    logic [DW-1:0] prev_rf;
    @(negedge clk);
    en = e; we = w; addr = a; wdata = d; oreg_ce = ce;
    old = ref_mem[a];
    prev_rf = exp_rf;
    if (e) begin
      if (w) begin
        exp_wf = d; exp_rf = old; ref_mem[a] = d;
      end else begin
        exp_wf = old; exp_rf = old; exp_nc = old;
      end
    end
    if (ce) exp_pp = prev_rf;
    @(posedge clk); #2;
    if (!e) begin
      chk("R5", "wf", rd_wf, exp_wf);
      chk("R5", "rf", rd_rf, exp_rf);
      chk("R5", "nc", rd_nc, exp_nc);
    end else if (w) begin
      chk("R2", "wf", rd_wf, exp_wf);
      chk("R3", "rf", rd_rf, exp_rf);
      chk("R4", "nc", rd_nc, exp_nc);
    end else begin
      chk("R1", "wf", rd_wf, exp_wf);
      chk("R1", "rf", rd_rf, exp_rf);
      chk("R1", "nc", rd_nc, exp_nc);
    end
    chk(ce ? "R6" : "R8", "pipe", rd_pp, exp_pp);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R7: zero output before any enabled access
    chk("R7", "wf", rd_wf, '0);
    chk("R7", "rf", rd_rf, '0);
    chk("R7", "nc", rd_nc, '0);
    chk("R7", "pipe", rd_pp, '0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 1'b1, 8'h05, 16'h9999, 1'b1);

    // Vector table walk
    for (int i = 0; i < NVEC; i++)
      step(VEC[i][25], VEC[i][24], VEC[i][23:16], VEC[i][15:0], 1'b1);

    // R8: stage held while its enable is low, latch moves on
    step(1'b1, 1'b0, 8'h20, 16'h0000, 1'b0);
    step(1'b1, 1'b0, 8'h30, 16'h0000, 1'b0);
    step(1'b0, 1'b0, 8'h30, 16'h0000, 1'b1);

    // R7 / R9: reset mid-run clears outputs, keeps memory
    @(negedge clk); rst_n = 1'b0;
    #2;
    chk("R7", "wf mid", rd_wf, '0);
    chk("R7", "pipe mid", rd_pp, '0);
    exp_wf = '0; exp_rf = '0; exp_nc = '0; exp_pp = '0;
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, 1'b0, 8'h10, 16'h0000, 1'b1);
    chk("R9", "kept word", rd_wf, 16'h3333);
    step(1'b0, 1'b0, 8'h00, 16'h0000, 1'b1);
    chk("R9", "kept word pipe", rd_pp, 16'h3333);

    finish_up();
  end
endmodule